// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block sits between a CPU core that issues byte, word and long-word operand transfers and a 16-bit external data bus. The slaves on that bus may be either 8 or 16 bits wide. A slave reports its width only through the two-bit active-low acknowledge it returns to end each bus cycle. The sequencer takes one request from the core and runs as many bus cycles as the slave's width needs. On each cycle it drives a size code that gives the number of operand bytes still to move, the current byte address, and the write data steered onto the upper and lower byte lanes.

On reads it picks the valid bytes out of each returned halfword. It packs them into the operand, most significant byte first, and hands the result to the core together with a one-cycle done pulse. Word and long-word requests at an odd address are rejected with an error pulse and cause no bus activity. Request size code 11 is rejected in the same way. Address decoding, arbitration and bus-error retry belong to other blocks.

Top module: `bsz_seq`

## Requirements
- R1: After synchronous reset, bus_cyc, core_done, core_err and core_busy are all 0.
- R2: The size code on bus_siz is the number of operand bytes still to move, modulo 4: 01 for one byte, 10 for two, 11 for three and 00 for four. A request uses the same size encoding, and byte requests may have any address.
- R3: A long-word request answered by an 8-bit port (ack 10) runs four cycles, with size codes 00, 11, 10, 01 in that order and the address rising by 1 each cycle. The long code 00 appears only at an even address.
- R4: A long-word request answered by a 16-bit port (ack_n[1]=0, ack_n[0] ignored) runs two cycles with size codes 00 then 10, and the address rises by 2.
- R5: A word request runs two cycles (10 then 01, address +1) on an 8-bit port and one cycle on a 16-bit port. A byte request always runs one cycle with code 01.
- R6: Operand bytes are numbered from the most significant end (OP0 first). If two or more bytes remain and the address is even, bus_dout[15:8] carries the current byte and bus_dout[7:0] the next one. Otherwise both lanes carry the current byte.
- R7: On reads, an 8-bit port's byte is taken from din[15:8]. A 16-bit port at an even address supplies bytes on [15:8] then [7:0], or only [15:8] for the last byte. At an odd address it supplies [7:0]. All other lanes are ignored. core_rdata is right-aligned and zero-extended.
- R8: A word or long-word request with address bit 0 set, or a request with size code 11, gives a one-cycle core_err pulse, starts no bus cycle and gives no core_done.
- R9: While bus_cyc is high and bus_ack_n is 11, bus_cyc, bus_wr, bus_siz, bus_addr and bus_dout hold. After an acknowledge, bus_cyc is low for exactly one cycle before the next cycle of the same transfer.
- R10: core_done pulses for one cycle, in the cycle after the final acknowledge, with core_rdata valid for reads. core_done never coincides with core_err, and a request while core_busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | One-cycle transfer request |
| core_wr | input | 1 | 1 = write, 0 = read |
| core_size | input | 2 | Requested size: 01 byte, 10 word, 00 long |
| core_addr | input | ADDR_W | Byte address of the operand |
| core_wdata | input | 32 | Write operand, right-aligned |
| core_busy | output | 1 | Transfer in progress |
| core_done | output | 1 | Transfer complete pulse |
| core_err | output | 1 | Rejected request pulse |
| core_rdata | output | 32 | Assembled read operand |
| bus_cyc | output | 1 | Bus cycle active |
| bus_wr | output | 1 | Bus cycle direction |
| bus_siz | output | 2 | Size code for the current cycle |
| bus_addr | output | ADDR_W | Current byte address |
| bus_dout | output | 16 | Write data lanes |
| bus_din | input | 16 | Read data lanes |
| bus_ack_n | input | 2 | Active-low acknowledge: 10 = 8-bit port, 0x = 16-bit port |

## Verification
Several properties are checked on every cycle: the bus holds steady while waiting for an acknowledge, a one-cycle gap follows each acknowledge, the long size code appears only at even addresses, odd-address cycles copy one byte onto both lanes, and done and error are single pulses that never overlap. Only the scenarios can show the exact order of size codes and addresses for each port width, the byte placement on the lanes for each size, the packing of read bytes while junk is driven on the unused lanes, and whether a request made while busy is really dropped.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 32;
  localparam int LANE_W = 16;

  typedef enum logic [1:0] {
    SZ_LONG   = 2'b00,
    SZ_BYTE   = 2'b01,
    SZ_WORD   = 2'b10,
    SZ_TRIPLE = 2'b11
  } siz_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } st_e;
endpackage

// File: rtl/bsz_wr_steer.sv
module bsz_wr_steer
  import bsz_pkg::*;
(
  input  logic [BYTE_W-1:0] op_cur,
  input  logic [BYTE_W-1:0] op_nxt,
  input  logic              addr0,
  input  logic              last,
  output logic [LANE_W-1:0] dout
);
  // a lone byte or an odd-address cycle carries one byte, copied on both lanes
  always_comb begin
    dout[LANE_W-1 -: BYTE_W] = op_cur;
    dout[BYTE_W-1:0]         = (addr0 || last) ? op_cur : op_nxt;
  end
endmodule

// File: rtl/bsz_rd_gather.sv
module bsz_rd_gather
  import bsz_pkg::*;
(
  input  logic [LANE_W-1:0]      din,
  input  logic                   port8,
  input  logic                   addr0,
  input  logic                   last,
  input  logic [OP_W-BYTE_W-1:0] acc,
  output logic                   take2,
  output logic [OP_W-1:0]        acc_nxt
);
  logic [BYTE_W-1:0] one_byte;

  always_comb begin
    take2    = !port8 && !addr0 && !last;
    one_byte = (port8 || !addr0) ? din[LANE_W-1 -: BYTE_W] : din[BYTE_W-1:0];
    if (take2) acc_nxt = {acc[OP_W-LANE_W-1:0], din};
    else       acc_nxt = {acc, one_byte};
  end
endmodule

// File: rtl/bsz_seq.sv
module bsz_seq
  import bsz_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_req,
  input  logic              core_wr,
  input  logic [1:0]        core_size,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [OP_W-1:0]   core_wdata,
  output logic              core_busy,
  output logic              core_done,
  output logic              core_err,
  output logic [OP_W-1:0]   core_rdata,
  output logic              bus_cyc,
  output logic              bus_wr,
  output logic [1:0]        bus_siz,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LANE_W-1:0] bus_dout,
  input  logic [LANE_W-1:0] bus_din,
  input  logic [1:0]        bus_ack_n
);
  localparam int NBYTES = OP_W / BYTE_W;
  localparam int REM_W  = $clog2(NBYTES + 1);

  st_e                   state;
  logic [REM_W-1:0]      rem;
  logic [OP_W-1:0]       wbuf;
  logic [OP_W-BYTE_W-1:0] rbuf;
  logic [OP_W-1:0]       rbuf_nxt;
  logic                  take2;
  logic                  ack_vld;
  logic                  last;
  logic [REM_W-1:0]      step;
  logic [REM_W-1:0]      rem_nxt;
  logic                  bad_req;

  assign ack_vld   = bus_cyc && (bus_ack_n != 2'b11);
  assign last      = (rem == REM_W'(1));
  assign step      = take2 ? REM_W'(2) : REM_W'(1);
  assign rem_nxt   = rem - step;
  assign bus_siz   = rem[1:0];
  assign core_busy = (state == ST_RUN);
  assign bad_req   = (core_size == SZ_TRIPLE) ||
                     ((core_size != SZ_BYTE) && core_addr[0]);

  bsz_wr_steer u_steer (
    .op_cur (wbuf[OP_W-1 -: BYTE_W]),
    .op_nxt (wbuf[OP_W-BYTE_W-1 -: BYTE_W]),
    .addr0  (bus_addr[0]),
    .last   (last),
    .dout   (bus_dout)
  );

  bsz_rd_gather u_gather (
    .din     (bus_din),
    .port8   (bus_ack_n[1]),
    .addr0   (bus_addr[0]),
    .last    (last),
    .acc     (rbuf),
    .take2   (take2),
    .acc_nxt (rbuf_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      rem        <= '0;
      wbuf       <= '0;
      rbuf       <= '0;
      bus_cyc    <= 1'b0;
      bus_wr     <= 1'b0;
      bus_addr   <= '0;
      core_done  <= 1'b0;
      core_err   <= 1'b0;
      core_rdata <= '0;
    end else begin
      core_done <= 1'b0;
      core_err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (core_req) begin
            if (bad_req) begin
              core_err <= 1'b1;
            end else begin
              state    <= ST_RUN;
              bus_cyc  <= 1'b1;
              bus_wr   <= core_wr;
              bus_addr <= core_addr;
              rbuf     <= '0;
              case (core_size)
                SZ_BYTE: begin
                  rem  <= REM_W'(1);
                  wbuf <= {core_wdata[BYTE_W-1:0], {(OP_W-BYTE_W){1'b0}}};
                end
                SZ_WORD: begin
                  rem  <= REM_W'(2);
                  wbuf <= {core_wdata[LANE_W-1:0], {(OP_W-LANE_W){1'b0}}};
                end
                default: begin
                  rem  <= REM_W'(NBYTES);
                  wbuf <= core_wdata;
                end
              endcase
            end
          end
        end
        default: begin
          if (!bus_cyc) begin
            bus_cyc <= 1'b1;
          end else if (ack_vld) begin
            bus_cyc  <= 1'b0;
            rbuf     <= rbuf_nxt[OP_W-BYTE_W-1:0];
            wbuf     <= take2 ? (wbuf << LANE_W) : (wbuf << BYTE_W);
            bus_addr <= bus_addr + ADDR_W'(step);
            rem      <= rem_nxt;
            if (rem_nxt == '0) begin
              state     <= ST_IDLE;
              core_done <= 1'b1;
              if (!bus_wr) core_rdata <= rbuf_nxt;
            end
          end
        end
      endcase
    end
  end

  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !ack_vld) |=> (bus_cyc && $stable(bus_siz) && $stable(bus_addr) && $stable(bus_dout) && $stable(bus_wr))); // R9
  AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    ack_vld |=> !bus_cyc); // R9
  AST_LONG_EVEN_ONLY: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_siz == SZ_LONG) |-> !bus_addr[0]); // R3
  AST_ODD_LANE_COPY: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_addr[0]) |-> (bus_dout[LANE_W-1 -: BYTE_W] == bus_dout[BYTE_W-1:0])); // R6
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    core_err |-> (!bus_cyc && !core_done)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    core_done |=> !core_done); // R10
endmodule

// File: tb/bsz_seq_tb_top.sv
module bsz_seq_tb_top;
  localparam int ADDR_W = 24;

  typedef struct packed {
    logic [1:0]        siz;
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic [15:0]       dout;
  } cyc_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic core_req = 1'b0, core_wr = 1'b0;
  logic [1:0] core_size = 2'b01;
  logic [ADDR_W-1:0] core_addr = '0;
  logic [31:0] core_wdata = '0;
  logic core_busy, core_done, core_err;
  logic [31:0] core_rdata;
  logic bus_cyc, bus_wr;
  logic [1:0] bus_siz;
  logic [ADDR_W-1:0] bus_addr;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = '0;
  logic [1:0] bus_ack_n = 2'b11;

  int checks = 0, errors = 0;
  int n_cycles = 0, n_done = 0, n_err = 0;
  bit port8 = 1'b0;
  int slave_wait = 0;
  cyc_t cq[$];
  string ctag[$];
  logic [31:0] rq[$];
  string rtag[$];

  always #2.5 clk = ~clk;

  bsz_seq #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .core_req(core_req), .core_wr(core_wr),
    .core_size(core_size), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_busy(core_busy), .core_done(core_done), .core_err(core_err),
    .core_rdata(core_rdata), .bus_cyc(bus_cyc), .bus_wr(bus_wr),
    .bus_siz(bus_siz), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_din(bus_din), .bus_ack_n(bus_ack_n)
  );

  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    return a[7:0] * 8'd7 + 8'h3D;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor and slave model: pops expected cycles, answers, pops read results
  initial begin
    cyc_t cur;
    string tg;
    bit seen = 1'b0, pend = 1'b0, alt = 1'b0;
    int wcnt = 0;
    forever begin
      @(negedge clk);
      if (core_done) begin
        n_done++;
        if (!bus_wr) begin
          if (rq.size() == 0) chk(1'b0, "R10 unexpected read done", 64'(core_rdata), 64'(0));
          else begin
            tg = rtag.pop_front();
            chk(core_rdata == rq[0], tg, 64'(core_rdata), 64'(rq[0]));
            void'(rq.pop_front());
          end
        end
      end
      if (core_err) n_err++;
      if (pend) begin
        bus_ack_n = 2'b11;
        bus_din   = 16'hDEAD;
        pend      = 1'b0;
        chk(!bus_cyc, "R9 gap after ack", 64'(bus_cyc), 64'(0));
      end else if (bus_cyc) begin
        if (!seen) begin
          seen = 1'b1; wcnt = 0; n_cycles++;
          if (cq.size() == 0) begin
            chk(1'b0, "R10 unexpected bus cycle", 64'(bus_addr), 64'(0));
            cur = '{siz: bus_siz, addr: bus_addr, wr: bus_wr, dout: bus_dout};
          end else begin
            cur = cq.pop_front();
            tg  = ctag.pop_front();
            chk(bus_siz == cur.siz, {tg, " size code"}, 64'(bus_siz), 64'(cur.siz));
            chk(bus_addr == cur.addr, {tg, " address"}, 64'(bus_addr), 64'(cur.addr));
            chk(bus_wr == cur.wr, {tg, " direction"}, 64'(bus_wr), 64'(cur.wr));
            if (cur.wr) chk(bus_dout == cur.dout, {tg, " write lanes R6"}, 64'(bus_dout), 64'(cur.dout));
          end
        end else begin
          chk(bus_siz == cur.siz && bus_addr == cur.addr && bus_dout == cur.dout,
              "R9 hold during wait", 64'({bus_siz, bus_addr, bus_dout}), 64'({cur.siz, cur.addr, cur.dout}));
        end
        if (wcnt >= slave_wait) begin
          alt = ~alt;
          bus_ack_n = port8 ? 2'b10 : {1'b0, alt};
          if (port8) bus_din = {mem_byte(bus_addr), ~mem_byte(bus_addr)};
          else bus_din = {mem_byte({bus_addr[ADDR_W-1:1], 1'b0}), mem_byte({bus_addr[ADDR_W-1:1], 1'b1})};
          pend = 1'b1; seen = 1'b0;
        end else wcnt++;
      end
    end
  end

  // driver: builds the expected cycle list from the requirements, then issues the request
  task automatic xfer(input string tag, input bit wr, input logic [1:0] sz,
                      input logic [ADDR_W-1:0] a, input logic [31:0] wd, input bit p8, input int wt);
    logic [7:0] ops [0:4];
    logic [ADDR_W-1:0] ca;
    logic [31:0] er;
    cyc_t it;
    int n, i, rem, stp, d0;
    bit single;
    n = (sz == 2'b01) ? 1 : (sz == 2'b10) ? 2 : 4;
    for (int k = 0; k < 5; k++) ops[k] = (k < n) ? wd[8*(n-1-k) +: 8] : 8'h00;
    port8 = p8; slave_wait = wt;
    i = 0; ca = a; rem = n; er = '0;
    while (rem > 0) begin
      single  = ca[0] || (rem == 1);
      it.siz  = rem[1:0];
      it.addr = ca;
      it.wr   = wr;
      it.dout = {ops[i], single ? ops[i] : ops[i+1]};
      cq.push_back(it); ctag.push_back(tag);
      stp = (p8 || single) ? 1 : 2;
      i += stp; ca += ADDR_W'(stp); rem -= stp;
    end
    for (int k = 0; k < n; k++) er = {er[23:0], mem_byte(a + ADDR_W'(k))};
    if (!wr) begin rq.push_back(er); rtag.push_back({tag, " read data R7"}); end
    d0 = n_done;
    @(negedge clk);
    core_req = 1'b1; core_wr = wr; core_size = sz; core_addr = a; core_wdata = wd;
    @(negedge clk);
    core_req = 1'b0;
    for (int t = 0; t < 400 && n_done == d0; t++) @(negedge clk);
    chk(n_done == d0 + 1, {tag, " done R10"}, 64'(n_done - d0), 64'(1));
    chk(cq.size() == 0, {tag, " cycle count"}, 64'(cq.size()), 64'(0));
    cq.delete(); ctag.delete();
  endtask

  task automatic expect_err(input string tag, input logic [1:0] sz, input logic [ADDR_W-1:0] a);
    int c0, d0, e0;
    c0 = n_cycles; d0 = n_done; e0 = n_err;
    @(negedge clk);
    core_req = 1'b1; core_wr = 1'b0; core_size = sz; core_addr = a;
    @(negedge clk);
    core_req = 1'b0;
    repeat (6) @(negedge clk);
    chk(n_err == e0 + 1, {tag, " err pulse"}, 64'(n_err - e0), 64'(1));
    chk(n_cycles == c0 && n_done == d0, {tag, " no bus cycle"}, 64'(n_cycles - c0), 64'(0));
    chk(!core_busy, {tag, " idle"}, 64'(core_busy), 64'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_cyc && !core_done && !core_err && !core_busy, "R1 reset state",
        64'({bus_cyc, core_done, core_err, core_busy}), 64'(0));

    xfer("R5 byte rd 8b even",  1'b0, 2'b01, 24'h000010, 32'h0, 1'b1, 0);
    xfer("R5 byte rd 8b odd",   1'b0, 2'b01, 24'h000011, 32'h0, 1'b1, 1);
    xfer("R7 byte rd 16b even", 1'b0, 2'b01, 24'h000020, 32'h0, 1'b0, 0);
    xfer("R7 byte rd 16b odd",  1'b0, 2'b01, 24'h000021, 32'h0, 1'b0, 2);
    xfer("R6 byte wr 16b odd",  1'b1, 2'b01, 24'h000033, 32'hFFFF_FF5C, 1'b0, 0);
    xfer("R6 byte wr 8b even",  1'b1, 2'b01, 24'h000034, 32'h0000_00A7, 1'b1, 0);
    xfer("R5 word rd 8b",       1'b0, 2'b10, 24'h000040, 32'h0, 1'b1, 1);
    xfer("R5 word wr 16b",      1'b1, 2'b10, 24'h000042, 32'h1234_BEEF, 1'b0, 0);
    xfer("R2 word wr 8b",       1'b1, 2'b10, 24'h000044, 32'h0000_C3D2, 1'b1, 0);
    xfer("R7 word rd 16b",      1'b0, 2'b10, 24'h000046, 32'h0, 1'b0, 3);
    xfer("R3 long rd 8b",       1'b0, 2'b00, 24'h000050, 32'h0, 1'b1, 0);
    xfer("R3 long wr 8b",       1'b1, 2'b00, 24'h000058, 32'h8899_AABB, 1'b1, 2);
    xfer("R4 long rd 16b",      1'b0, 2'b00, 24'h000060, 32'h0, 1'b0, 1);
    xfer("R4 long wr 16b",      1'b1, 2'b00, 24'h000064, 32'h0102_0304, 1'b0, 0);
    xfer("R9 long rd 16b slow", 1'b0, 2'b00, 24'hFFFFFC, 32'h0, 1'b0, 5);

    expect_err("R8 word odd",  2'b10, 24'h000071);
    expect_err("R8 long odd",  2'b00, 24'h000073);
    expect_err("R8 size 11",   2'b11, 24'h000074);

    // request while busy must be dropped
    fork
      xfer("R10 busy ignore", 1'b0, 2'b00, 24'h000080, 32'h0, 1'b1, 2);
      begin
        repeat (4) @(negedge clk);
        core_req = 1'b1; core_wr = 1'b1; core_size = 2'b10; core_addr = 24'h000100;
        @(negedge clk);
        core_req = 1'b0;
      end
    join
    c0 = n_cycles;
    repeat (10) @(negedge clk);
    chk(n_cycles == c0 && !core_busy, "R10 busy request dropped", 64'(n_cycles - c0), 64'(0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule